// File: doc/BRIEF.md
# Taint Policy Guard

This block sits beside the controller of a hardware accelerator that tracks taint tags on its data. Each cycle it sees two kinds of events. The first is a branch condition the controller is about to act on, given with its one-bit taint tag and a flag marking the transition as critical. The second is an external memory request, given with a per-bit taint tag for its address and a flag marking the pointer as critical. A programmable policy decides whether either event is a security violation.

A memory request that breaks the policy is blocked in the same cycle, so it never reaches the memory bus. From the next cycle the block holds the accelerator with a halt output and raises a security interrupt. Both stay high until software writes a one to bit 0 of the status register. Software programs the policy and reads the cause through a small register port. While the halt is held, every memory request is blocked and no new violation is recorded.

Top module: `taint_policy_guard`

## Requirements
- R1: After reset, halt and sec_irq are low, the control register (offset 0) reads 0x00000005 and the status register (offset 1) reads 0.
- R2: With branch checking on (control bit 0) and the critical-only bit (control bit 1) clear, a cond_valid cycle with cond_tag high sets halt and sec_irq on the next cycle and sets status bit 1 (branch cause).
- R3: With control bit 1 set, a tainted condition raises a violation only when cond_critical is high.
- R4: With memory checking on (control bit 2) and strict mode (control bit 3 clear), a request with any bit of mem_addr_tag set is not forwarded on mem_req_out in that cycle. From the next cycle halt is high and status bit 2 (memory cause) is set.
- R5: In permissive mode (control bit 3 set), only the top N tag bits are checked, where N is control bits [13:8]. N=0 checks no bit and N at least ADDR_W checks every bit.
- R6: With control bit 4 set, a request whose mem_critical is low is treated as benign and forwarded whatever its tag.
- R7: A request that breaks no policy while halt is low is forwarded on mem_req_out in the same cycle, and mem_req_out is never high without mem_req.
- R8: halt and sec_irq stay high, always equal, until a write to offset 1 with data bit 0 set. That write clears halt, sec_irq and every status bit. A write with bit 0 clear has no effect.
- R9: While halt is high, mem_req_out stays low and further violations leave the status cause bits unchanged.
- R10: A branch violation and a memory violation in the same cycle set both status bits 1 and 2.
- R11: With control bits 0 and 2 clear, tainted conditions and requests raise no violation and requests are forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cond_valid | input | 1 | Branch condition is being used this cycle |
| cond_tag | input | 1 | Taint tag of the condition |
| cond_critical | input | 1 | Transition marked critical |
| mem_req | input | 1 | External memory request from the accelerator |
| mem_addr_tag | input | ADDR_W | Per-bit taint tag of the request address |
| mem_critical | input | 1 | Pointer marked critical |
| mem_req_out | output | 1 | Request forwarded to the memory bus |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | REG_AW | Register offset (0 control, 1 status) |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Register read data (combinational) |
| halt | output | 1 | Holds the accelerator |
| sec_irq | output | 1 | Security interrupt |

## Verification
The checker watches on every cycle that no request is forwarded without a request or while halted, that a clean request passes when not halted, that the interrupt always matches the halt, that the halt never drops without a clearing write, and that a rising halt always follows a tainted event. Which policy bit masks which event, how wide the permissive window is, and which cause bits get recorded can only be shown by the bench's scenarios. The bench walks a table of policy settings and events and compares the forwarded strobe and the status word against expected values. Directed cases then cover reset, clearing, halted behaviour and the window limits.

// File: rtl/taint_policy_guard.sv
module taint_policy_guard #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int REG_AW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cond_valid,
  input  logic              cond_tag,
  input  logic              cond_critical,
  input  logic              mem_req,
  input  logic [ADDR_W-1:0] mem_addr_tag,
  input  logic              mem_critical,
  output logic              mem_req_out,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              halt,
  output logic              sec_irq
);
  localparam int CNT_W   = $clog2(ADDR_W + 1);
  localparam int CNT_LSB = 8;
  localparam logic [REG_AW-1:0] OFS_CTRL = REG_AW'(0);
  localparam logic [REG_AW-1:0] OFS_STAT = REG_AW'(1);

  logic             br_en, br_crit_only, mem_en, mem_perm, mem_crit_only;
  logic [CNT_W-1:0] msb_n;
  logic             active, cause_br, cause_mem;
  logic [ADDR_W-1:0] hi_mask, chk_tag;
  logic [DATA_W-1:0] ctrl_word;

  wire ctrl_wr = cfg_we && (cfg_addr == OFS_CTRL);
  wire stat_wr = cfg_we && (cfg_addr == OFS_STAT);

  for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
    assign hi_mask[i] = 32'(msb_n) > 32'(ADDR_W - 1 - i);
  end

  assign chk_tag = mem_perm ? (mem_addr_tag & hi_mask) : mem_addr_tag;

  wire br_viol  = !active && cond_valid && br_en && cond_tag &&
                  (!br_crit_only || cond_critical);
  wire mem_viol = !active && mem_req && mem_en &&
                  (!mem_crit_only || mem_critical) && (|chk_tag);

  assign mem_req_out = mem_req && !active && !mem_viol;
  assign halt        = active;
  assign sec_irq     = active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      br_en         <= 1'b1;
      br_crit_only  <= 1'b0;
      mem_en        <= 1'b1;
      mem_perm      <= 1'b0;
      mem_crit_only <= 1'b0;
      msb_n         <= '0;
    end else if (ctrl_wr) begin
      br_en         <= cfg_wdata[0];
      br_crit_only  <= cfg_wdata[1];
      mem_en        <= cfg_wdata[2];
      mem_perm      <= cfg_wdata[3];
      mem_crit_only <= cfg_wdata[4];
      msb_n         <= cfg_wdata[CNT_LSB +: CNT_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      cause_br  <= 1'b0;
      cause_mem <= 1'b0;
    end else if (br_viol || mem_viol) begin
      active    <= 1'b1;
      cause_br  <= br_viol;
      cause_mem <= mem_viol;
    end else if (stat_wr && cfg_wdata[0]) begin
      active    <= 1'b0;
      cause_br  <= 1'b0;
      cause_mem <= 1'b0;
    end
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[0] = br_en;
    ctrl_word[1] = br_crit_only;
    ctrl_word[2] = mem_en;
    ctrl_word[3] = mem_perm;
    ctrl_word[4] = mem_crit_only;
    ctrl_word[CNT_LSB +: CNT_W] = msb_n;
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_addr == OFS_CTRL) cfg_rdata = ctrl_word;
    else if (cfg_addr == OFS_STAT) cfg_rdata[2:0] = {cause_mem, cause_br, active};
  end

  wire unused_wdata = ^cfg_wdata;
endmodule

// File: rtl/taint_policy_guard_chk.sv
module taint_policy_guard_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int REG_AW = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cond_valid,
  input logic              cond_tag,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr_tag,
  input logic              mem_req_out,
  input logic              cfg_we,
  input logic [REG_AW-1:0] cfg_addr,
  input logic [DATA_W-1:0] cfg_wdata,
  input logic              halt,
  input logic              sec_irq
);
  wire clr_wr = cfg_we && (cfg_addr == REG_AW'(1)) && cfg_wdata[0];

  assert_fwd_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_out |-> mem_req);

  assert_clean_passes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !halt && mem_addr_tag == '0) |-> mem_req_out);

  assert_blocked_while_halted_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !mem_req_out);

  assert_irq_matches_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sec_irq == halt);

  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !clr_wr) |=> halt);

  assert_halt_has_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt ##1 halt) |-> $past((cond_valid && cond_tag) || (mem_req && |mem_addr_tag)));
endmodule

bind taint_policy_guard taint_policy_guard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_AW(REG_AW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cond_valid(cond_valid), .cond_tag(cond_tag),
  .mem_req(mem_req), .mem_addr_tag(mem_addr_tag), .mem_req_out(mem_req_out),
  .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
  .halt(halt), .sec_irq(sec_irq)
);

// File: tb/taint_policy_guard_tb_top.sv
`timescale 1ns/1ps
module taint_policy_guard_tb_top;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int REG_AW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cond_valid = 0, cond_tag = 0, cond_critical = 0;
  logic mem_req = 0, mem_critical = 0;
  logic [ADDR_W-1:0] mem_addr_tag = '0;
  logic mem_req_out;
  logic cfg_we = 0;
  logic [REG_AW-1:0] cfg_addr = '0;
  logic [DATA_W-1:0] cfg_wdata = '0;
  logic [DATA_W-1:0] cfg_rdata;
  logic halt, sec_irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  taint_policy_guard #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_AW(REG_AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cond_valid(cond_valid), .cond_tag(cond_tag),
    .cond_critical(cond_critical), .mem_req(mem_req), .mem_addr_tag(mem_addr_tag),
    .mem_critical(mem_critical), .mem_req_out(mem_req_out), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .halt(halt), .sec_irq(sec_irq));

  // {ctrl[32], cv, ct, cc, mr, mc, tag[32], exp_fwd, exp_halt, exp_cause{mem,br}}
  localparam int NV = 13;
  localparam logic [72:0] VEC [NV] = '{
    {32'h05, 5'b11000, 32'h0,        1'b0, 1'b1, 2'b01}, // R2
    {32'h07, 5'b11000, 32'h0,        1'b0, 1'b0, 2'b00}, // R3 non-critical
    {32'h07, 5'b11100, 32'h0,        1'b0, 1'b1, 2'b01}, // R3 critical
    {32'h05, 5'b00010, 32'h1,        1'b0, 1'b1, 2'b10}, // R4
    {32'h05, 5'b00010, 32'h0,        1'b1, 1'b0, 2'b00}, // R7
    {32'h40C, 5'b00010, 32'h0FFFFFFF, 1'b1, 1'b0, 2'b00}, // R5 below window
    {32'h40C, 5'b00010, 32'h10000000, 1'b0, 1'b1, 2'b10}, // R5 in window
    {32'h15, 5'b00010, 32'hFFFFFFFF, 1'b1, 1'b0, 2'b00}, // R6 benign
    {32'h15, 5'b00011, 32'h1,        1'b0, 1'b1, 2'b10}, // R6 critical
    {32'h05, 5'b11010, 32'h80000000, 1'b0, 1'b1, 2'b11}, // R10
    {32'h00, 5'b11110, 32'hFFFFFFFF, 1'b1, 1'b0, 2'b00}, // R11
    {32'h200C, 5'b00010, 32'h1,      1'b0, 1'b1, 2'b10}, // R5 N=32
    {32'h0C, 5'b00010, 32'hFFFFFFFF, 1'b1, 1'b0, 2'b00}  // R5 N=0
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [REG_AW-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0; cfg_wdata = '0;
  endtask

  task automatic read_stat(output logic [31:0] v);
    cfg_addr = REG_AW'(1);
    #0.5 v = cfg_rdata;
  endtask

  task automatic drive(input logic [4:0] f, input logic [31:0] tag);
    {cond_valid, cond_tag, cond_critical, mem_req, mem_critical} = f;
    mem_addr_tag = tag;
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #0.5;
    check("R1 halt", {31'b0, halt}, 0);
    check("R1 irq", {31'b0, sec_irq}, 0);
    cfg_addr = '0; #0.5;
    check("R1 ctrl", cfg_rdata, 32'h5);
    read_stat(s);
    check("R1 status", s, 0);

    for (int i = 0; i < NV; i++) begin
      cfg_write(0, VEC[i][72:41]);
      cfg_write(1, 1);
      drive(VEC[i][40:36], VEC[i][35:4]);
      #0.5;
      check($sformatf("R4/R7 vec%0d fwd", i), {31'b0, mem_req_out}, {31'b0, VEC[i][3]});
      @(negedge clk);
      drive(5'b0, 0);
      read_stat(s);
      check($sformatf("R2/R8 vec%0d halt", i), {31'b0, halt}, {31'b0, VEC[i][2]});
      check($sformatf("R2/R10 vec%0d status", i), s, {29'b0, VEC[i][1:0], VEC[i][2]});
    end

    // R8: sticky until W1C
    cfg_write(1, 1);
    cfg_write(0, 32'h05);
    @(negedge clk); drive(5'b11000, 0);
    @(negedge clk); drive(5'b0, 0);
    repeat (4) @(negedge clk);
    check("R8 held", {31'b0, halt}, 1);
    cfg_write(1, 32'h6);
    #0.5;
    check("R8 write bit0 clear no effect", {31'b0, halt}, 1);
    check("R8 irq equal", {31'b0, sec_irq}, 1);

    // R9: halted, clean request blocked, new memory violation leaves cause
    drive(5'b00010, 0);
    #0.5;
    check("R9 clean blocked", {31'b0, mem_req_out}, 0);
    @(negedge clk); drive(5'b00010, 32'hFF);
    @(negedge clk); drive(5'b0, 0);
    read_stat(s);
    check("R9 cause unchanged", s, 32'h3);

    cfg_write(1, 1);
    read_stat(s);
    check("R8 cleared status", s, 0);
    check("R8 cleared irq", {31'b0, sec_irq}, 0);
    drive(5'b00010, 0);
    #0.5;
    check("R7 forwards after clear", {31'b0, mem_req_out}, 1);
    @(negedge clk); drive(5'b0, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule